// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block is the add/subtract slice of a RISC integer pipeline. A single full adder serves every variant: an operand stage picks the first addend (operand A or its bitwise complement), the second addend (operand B, zero or all ones) and the carry-in (0, 1 or the incoming carry flag). The adder's top carry bit is the carry-out, and a sign comparison of the addends and the sum gives signed overflow.

The pipeline supplies the current carry (CA), overflow (OV) and summary-overflow (SO) bits with each operation, along with two enables: one for recording the carry and one for recording overflow. The result and the updated flags are registered on the clock edge where the input valid strobe is high. Subtraction is always "B minus A". The summary-overflow bit is sticky, so the unit can set it but never clear it. Writing the flags back to an architectural register is left to the surrounding pipeline.

Top module: `addsub_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the registered result, CA, OV, SO and the output valid strobe.
- R2: The add forms give the sum modulo 2^W: opcode 0 gives A+B, opcode 1 gives A+B+CA, opcode 2 gives A+CA-1, opcode 3 gives A+CA.
- R3: The subtract-from forms give the complement of A plus a second term plus a carry-in: opcode 4 gives B+~A+1 (B minus A), opcode 5 gives B+~A+CA, opcode 6 gives ~A+CA-1, opcode 7 gives ~A+CA.
- R4: Opcode 8 gives the negation of A (~A+1). For the most negative input (only the sign bit set) the result equals the input and overflow is flagged.
- R5: When the carry-record enable is set, the registered CA is bit W of the full adder sum. When it is clear, the registered CA equals the incoming CA.
- R6: When the overflow-record enable is set, OV is 1 exactly when both addends have the same sign bit and the sum's sign bit differs from it, and 0 otherwise. When the enable is clear, the registered OV equals the incoming OV.
- R7: SO becomes 1 when overflow is recorded and detected. In every other case SO equals the incoming SO, so the unit never clears it.
- R8: Outputs are registered. The output valid strobe follows the input valid strobe by one cycle, and while the input valid strobe is low the result and the flags hold their values.
- R9: With carry recording, opcode 2 yields CA=1 for any nonzero A, and opcode 6 yields CA=1 for any A that is not all ones, whatever the incoming CA.
- R10: The opcodes 9 to 15 are undefined and behave as opcode 0 (plain add).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Variant select (codes in R2 to R4, R10) |
| rec_ca | input | 1 | Record the carry-out into CA |
| rec_ov | input | 1 | Record overflow into OV and SO |
| a | input | W | Operand A (the subtrahend in subtract-from forms) |
| b | input | W | Operand B |
| ca_in | input | 1 | Current carry flag |
| ov_in | input | 1 | Current overflow flag |
| so_in | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | Result and flags valid |
| result | output | W | Registered result |
| ca_out | output | 1 | Updated carry flag |
| ov_out | output | 1 | Updated overflow flag |
| so_out | output | 1 | Updated summary-overflow flag |

## Verification
The only internal state is the output register stage. A wrong addend selection or carry-in shows up as a wrong result or CA on the cycle right after the strobe. A fault in the flag-merge logic shows as OV or SO differing from the incoming bits on that same cycle. A register that updates without a strobe, or that fails to clear on reset, is visible one cycle later as a changed result or flag while out_valid is low. The vector table covers the carry and sign boundaries of every opcode, and directed steps cover reset, hold and the cases where recording is disabled.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_ADDM1  = 4'd2,
    OP_ADDZ   = 4'd3,
    OP_SUBF   = 4'd4,
    OP_SUBFC  = 4'd5,
    OP_SUBFM1 = 4'd6,
    OP_SUBFZ  = 4'd7,
    OP_NEG    = 4'd8
  } addsub_op_e;

  typedef enum logic [1:0] {
    SEL_B    = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_ONES = 2'd2
  } second_sel_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CA   = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic        inv_a;
    second_sel_e sec;
    cin_sel_e    cin;
  } op_ctrl_t;

  function automatic op_ctrl_t decode_op(input logic [3:0] code);
    op_ctrl_t c;
    c = '{inv_a: 1'b0, sec: SEL_B, cin: CIN_ZERO};
    case (code)
      OP_ADDC:   c = '{inv_a: 1'b0, sec: SEL_B,    cin: CIN_CA};
      OP_ADDM1:  c = '{inv_a: 1'b0, sec: SEL_ONES, cin: CIN_CA};
      OP_ADDZ:   c = '{inv_a: 1'b0, sec: SEL_ZERO, cin: CIN_CA};
      OP_SUBF:   c = '{inv_a: 1'b1, sec: SEL_B,    cin: CIN_ONE};
      OP_SUBFC:  c = '{inv_a: 1'b1, sec: SEL_B,    cin: CIN_CA};
      OP_SUBFM1: c = '{inv_a: 1'b1, sec: SEL_ONES, cin: CIN_CA};
      OP_SUBFZ:  c = '{inv_a: 1'b1, sec: SEL_ZERO, cin: CIN_CA};
      OP_NEG:    c = '{inv_a: 1'b1, sec: SEL_ZERO, cin: CIN_ONE};
      default:   c = '{inv_a: 1'b0, sec: SEL_B,    cin: CIN_ZERO};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ca_in,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         cin
);

  op_ctrl_t ctrl;

  always_comb begin
    ctrl = decode_op(op);
    x = ctrl.inv_a ? ~a : a;
    case (ctrl.sec)
      SEL_ZERO: y = '0;
      SEL_ONES: y = '1;
      default:  y = b;
    endcase
    case (ctrl.cin)
      CIN_ONE: cin = 1'b1;
      CIN_CA:  cin = ca_in;
      default: cin = 1'b0;
    endcase
  end

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W       = 32,
  parameter bit RIPPLE  = 1'b0
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int MSB = W - 1;

  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0]   chain;
      logic [W-1:0] s_r;
      always_comb begin
        chain    = '0;
        s_r      = '0;
        chain[0] = cin;
        for (int i = 0; i < W; i++) begin
          s_r[i]     = x[i] ^ y[i] ^ chain[i];
          chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
        end
      end
      assign sum  = s_r;
      assign cout = chain[W];
    end else begin : g_flat
      logic [W:0] wide;
      assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      assign sum  = wide[W-1:0];
      assign cout = wide[W];
    end
  endgenerate

  assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         rec_ca,
  input  logic         rec_ov,
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         ovf,
  input  logic         ca_in,
  input  logic         ov_in,
  input  logic         so_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ca_out,
  output logic         ov_out,
  output logic         so_out
);

  logic ca_nxt, ov_nxt, so_nxt;

  always_comb begin
    ca_nxt = rec_ca ? cout : ca_in;
    ov_nxt = rec_ov ? ovf  : ov_in;
    so_nxt = so_in | (rec_ov & ovf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ca_out    <= 1'b0;
      ov_out    <= 1'b0;
      so_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum;
        ca_out <= ca_nxt;
        ov_out <= ov_nxt;
        so_out <= so_nxt;
      end
    end
  end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         rec_ca,
  input  logic         rec_ov,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ca_in,
  input  logic         ov_in,
  input  logic         so_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ca_out,
  output logic         ov_out,
  output logic         so_out
);

  logic [W-1:0] x_add, y_add, sum_w;
  logic         cin_w, cout_w, ovf_w;

  addsub_operand_prep #(.W(W)) u_prep (
    .op    (op),
    .a     (a),
    .b     (b),
    .ca_in (ca_in),
    .x     (x_add),
    .y     (y_add),
    .cin   (cin_w)
  );

  addsub_core #(.W(W), .RIPPLE(RIPPLE)) u_core (
    .x    (x_add),
    .y    (y_add),
    .cin  (cin_w),
    .sum  (sum_w),
    .cout (cout_w),
    .ovf  (ovf_w)
  );

  addsub_flag_reg #(.W(W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rec_ca    (rec_ca),
    .rec_ov    (rec_ov),
    .sum       (sum_w),
    .cout      (cout_w),
    .ovf       (ovf_w),
    .ca_in     (ca_in),
    .ov_in     (ov_in),
    .so_in     (so_in),
    .out_valid (out_valid),
    .result    (result),
    .ca_out    (ca_out),
    .ov_out    (ov_out),
    .so_out    (so_out)
  );

endmodule

// File: rtl/addsub_flag_unit_chk.sv
module addsub_flag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic         rec_ca,
  input logic         rec_ov,
  input logic [W-1:0] a,
  input logic         ca_in,
  input logic         ov_in,
  input logic         so_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         ca_out,
  input logic         ov_out,
  input logic         so_out
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !ca_out && !ov_out && !so_out && result == '0));

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ca_out)
                   && $stable(ov_out) && $stable(so_out)));

  assert_ca_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_ca) |=> ca_out == $past(ca_in));

  assert_ov_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_ov) |=> (ov_out == $past(ov_in) && so_out == $past(so_in)));

  assert_so_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && so_in) |=> so_out);

  assert_so_merge_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rec_ov) |=> so_out == ($past(so_in) | ov_out));

  assert_neg_min_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd8 && a == MOST_NEG && rec_ov)
      |=> (result == MOST_NEG && ov_out && so_out));

endmodule

bind addsub_flag_unit addsub_flag_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .rec_ca    (rec_ca),
  .rec_ov    (rec_ov),
  .a         (a),
  .ca_in     (ca_in),
  .ov_in     (ov_in),
  .so_in     (so_in),
  .out_valid (out_valid),
  .result    (result),
  .ca_out    (ca_out),
  .ov_out    (ov_out),
  .so_out    (so_out)
);

// File: tb/addsub_flag_unit_test.sv
module addsub_flag_unit_test;

  localparam int W = 32;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        ci;
    logic        oi;
    logic        si;
    logic        rc;
    logic        ro;
    logic [31:0] er;
    logic        eca;
    logic        eov;
    logic        eso;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    // op     a             b             ci    oi    si    rc    ro    result        ca    ov    so
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1}, // R2 R6
    '{4'd0, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd1, 32'h00000001, 32'h00000002, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h00000004, 1'b0, 1'b0, 1'b1}, // R2 R7
    '{4'd2, 32'h00000000, 32'h12345678, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd2, 32'h00000005, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000004, 1'b1, 1'b0, 1'b0}, // R9
    '{4'd3, 32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1}, // R2 R6
    '{4'd4, 32'h00000003, 32'h0000000A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000007, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd4, 32'h00000005, 32'h00000003, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4, 32'h00000001, 32'h80000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b1}, // R3 R6
    '{4'd5, 32'h00000005, 32'h00000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFD, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd6, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd6, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0}, // R9
    '{4'd7, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd8, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b1}, // R4
    '{4'd8, 32'h00000005, 32'h00000000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFFFFFB, 1'b0, 1'b0, 1'b1}, // R4 R7
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R5 R6
    '{4'd15, 32'h00000002, 32'h00000003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000005, 1'b0, 1'b0, 1'b0}  // R10
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic         rec_ca = 1'b0;
  logic         rec_ov = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         ca_in = 1'b0;
  logic         ov_in = 1'b0;
  logic         so_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         ca_out, ov_out, so_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  addsub_flag_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .rec_ca(rec_ca), .rec_ov(rec_ov), .a(a), .b(b),
    .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
    .out_valid(out_valid), .result(result),
    .ca_out(ca_out), .ov_out(ov_out), .so_out(so_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic ci, input logic oi, input logic si,
                       input logic rc, input logic ro);
    op = o; a = av; b = bv; ca_in = ci; ov_in = oi; so_in = si;
    rec_ca = rc; rec_ov = ro; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {31'd0, out_valid}, 0);
    check("R1 result", result, 0);
    check("R1 flags", {29'd0, ca_out, ov_out, so_out}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].ci, TBL[i].oi, TBL[i].si,
            TBL[i].rc, TBL[i].ro);
      check($sformatf("R2/R3/R4/R10 result vec%0d", i), result, TBL[i].er);
      check($sformatf("R5/R9 ca vec%0d", i), {31'd0, ca_out}, {31'd0, TBL[i].eca});
      check($sformatf("R6 ov vec%0d", i), {31'd0, ov_out}, {31'd0, TBL[i].eov});
      check($sformatf("R7 so vec%0d", i), {31'd0, so_out}, {31'd0, TBL[i].eso});
      check($sformatf("R8 valid vec%0d", i), {31'd0, out_valid}, 1);
    end

    // R8: with no strobe, outputs hold despite changed inputs
    issue(4'd0, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    op = 4'd4; a = 32'h1; b = 32'h0; ca_in = 1'b1; ov_in = 1'b0; so_in = 1'b0;
    @(negedge clk);
    check("R8 hold valid", {31'd0, out_valid}, 0);
    check("R8 hold result", result, 32'h80000000);
    check("R8 hold flags", {29'd0, ca_out, ov_out, so_out}, 32'd3);

    // R7: no overflow with sticky SO stays set while OV clears
    issue(4'd4, 32'h1, 32'h1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R7 sticky so", {31'd0, so_out}, 1);
    check("R6 ov cleared", {31'd0, ov_out}, 0);
    check("R3 b-a zero", result, 0);
    check("R5 carry on equal", {31'd0, ca_out}, 1);

    // R9: subtract-from-minus-one with CA=1 and A nonzero
    issue(4'd6, 32'h00000010, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 subfm1 result", result, 32'hFFFFFFEF);
    check("R9 subfm1 ca", {31'd0, ca_out}, 1);

    // R1: reset after flags were set
    issue(4'd8, 32'h80000000, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears flags", {29'd0, ca_out, ov_out, so_out}, 0);
    check("R1 reset clears result", result, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule